// File: doc/BRIEF.md
# Cache Write-Policy Controller

This block decides, for every processor write that reaches a cache, whether the cache array is written, whether main memory is written, and whether a line fill is needed first. It also handles the memory side of an eviction. It keeps two status bits for each cache line. The dirty bit marks a line whose cache copy is newer than memory. The written-once bit marks a line that has already had one write sent through to memory. A two-bit policy input selects write-back, write-through or write-once behaviour. Tag lookup, the data arrays and the choice of victim line stay outside the block. The caller supplies a hit/miss flag and a line index with each write, and a line index with each eviction.

The write port and the eviction port are valid/ready streams. A request is taken on a clock edge where both valid and ready are high. Ready is high only while the controller is idle, so the caller must hold valid and its payload until that edge. An eviction has priority: while `evict_valid` is high, `wr_ready` is low. Toward memory, `mem_req` acts as valid and `mem_ack` as ready. The request, its line and its kind stay stable until an edge where `mem_ack` is high. Line fills use the same pattern with `fill_req` and `fill_ack`. The cache-write strobe is a one-cycle pulse, registered one edge after the write is accepted or the fill is acknowledged.

Top module: `wp_ctrl`

## Requirements
- R1: After reset every dirty and written-once bit is 0, `mem_req`, `fill_req` and `cache_we` are 0, and both `wr_ready` and `evict_ready` are 1.
- R2: Policy code 0 (write-back): a write hit pulses `cache_we` for the hit line in the cycle after acceptance, sets that line's dirty bit, and raises no memory request.
- R3: Policy codes 0 and 2: a write miss raises `fill_req` with the line index and no memory write. `fill_req` holds until an edge with `fill_ack`. After that edge, `cache_we` pulses, the line's dirty bit is 1 and its written-once bit is 0.
- R4: Policy code 1 (write-through): a write hit pulses `cache_we` and raises `mem_req` with `mem_wb`=0 for that line. No dirty bit changes.
- R5: Policy code 1: a write miss raises `mem_req` with `mem_wb`=0 for that line, with no `cache_we` pulse and no fill request.
- R6: Policy code 2 (write-once): a write hit to a line whose written-once bit is 0 pulses `cache_we`, raises `mem_req` with `mem_wb`=0, and sets the written-once bit. The dirty bit is left unchanged.
- R7: Policy code 2: a write hit to a line whose written-once bit is 1 pulses `cache_we`, sets the dirty bit, and raises no memory request.
- R8: An accepted eviction of a dirty line raises `mem_req` with `mem_wb`=1 (whole-line writeback) and `mem_line` equal to the evicted index. The line's dirty and written-once bits are cleared.
- R9: An accepted eviction of a clean line raises no memory request and clears the line's written-once bit.
- R10: While `mem_req` waits for `mem_ack`, it holds its line and kind. While `mem_req` or `fill_req` is open, `wr_ready` and `evict_ready` are 0.
- R11: When the controller is idle and `evict_valid` is high, `wr_ready` is 0. The eviction is taken even if a write is also valid.
- R12: Policy code 3 behaves exactly as write-back: a write hit sets the dirty bit and raises no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | 0 write-back, 1 write-through, 2 write-once, 3 as write-back |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted when high with valid |
| wr_hit | input | 1 | 1 = target line present in cache |
| wr_line | input | IW | Line index of the write |
| evict_valid | input | 1 | Eviction request valid |
| evict_ready | output | 1 | Eviction accepted when high with valid |
| evict_line | input | IW | Line index being evicted |
| cache_we | output | 1 | One-cycle cache array write strobe |
| cache_line | output | IW | Line for the cache write |
| fill_req | output | 1 | Line fill request (held until acknowledged) |
| fill_line | output | IW | Line to be filled |
| fill_ack | input | 1 | Fill complete |
| mem_req | output | 1 | Memory write request (held until acknowledged) |
| mem_wb | output | 1 | 1 = dirty-line writeback, 0 = single write-through word |
| mem_line | output | IW | Line index for the memory write |
| mem_ack | input | 1 | Memory accepted the write |
| dirty_o | output | LINES | Per-line dirty bits |
| wonce_o | output | LINES | Per-line written-once bits |

## Verification
The hardest case to reach is a line that carries both status bits at the moment it is evicted. The stimulus builds it in steps under the write-once policy: a first hit is sent through to memory and acknowledged, then a second hit to the same line sets the dirty bit. The eviction then has to produce a writeback and clear both bits. The bench also raises an eviction and a write in the same cycle to show the eviction takes the slot. It holds `mem_ack` low for several cycles so that the request and both ready outputs can be watched while the request is stalled.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [1:0] {
    POL_WB = 2'd0,
    POL_WT = 2'd1,
    POL_WO = 2'd2
  } pol_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_MEM  = 2'd2
  } st_e;

  typedef struct packed {
    logic cache_wr;
    logic mem_wr;
    logic fill;
    logic set_dirty;
    logic set_wonce;
  } wr_dec_t;

endpackage

// File: rtl/wp_decide.sv
module wp_decide
  import wp_pkg::*;
(
  input  logic [1:0] pol,
  input  logic       hit,
  input  logic       wonce_bit,
  output wr_dec_t    dec
);

  always_comb begin
    dec = '0;
    case (pol)
      POL_WT: begin
        dec.cache_wr = hit;
        dec.mem_wr   = 1'b1;
      end
      POL_WO: begin
        if (!hit) begin
          dec.fill = 1'b1;
        end else if (!wonce_bit) begin
          dec.cache_wr  = 1'b1;
          dec.mem_wr    = 1'b1;
          dec.set_wonce = 1'b1;
        end else begin
          dec.cache_wr  = 1'b1;
          dec.set_dirty = 1'b1;
        end
      end
      default: begin
        if (hit) begin
          dec.cache_wr  = 1'b1;
          dec.set_dirty = 1'b1;
        end else begin
          dec.fill = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/wp_line_status.sv
module wp_line_status #(
  parameter int LINES = 8,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    idx,
  input  logic             set_d,
  input  logic             clr_d,
  input  logic             set_w,
  input  logic             clr_w,
  output logic [LINES-1:0] dirty,
  output logic [LINES-1:0] wonce
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel;
    logic d_q;
    logic w_q;

    assign sel = (idx == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        d_q <= 1'b0;
        w_q <= 1'b0;
      end else if (sel) begin
        d_q <= (d_q & ~clr_d) | set_d;
        w_q <= (w_q & ~clr_w) | set_w;
      end
    end

    assign dirty[g] = d_q;
    assign wonce[g] = w_q;
  end

endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int LINES = 8,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_hit,
  input  logic [IW-1:0]    wr_line,
  input  logic             evict_valid,
  output logic             evict_ready,
  input  logic [IW-1:0]    evict_line,
  output logic             cache_we,
  output logic [IW-1:0]    cache_line,
  output logic             fill_req,
  output logic [IW-1:0]    fill_line,
  input  logic             fill_ack,
  output logic             mem_req,
  output logic             mem_wb,
  output logic [IW-1:0]    mem_line,
  input  logic             mem_ack,
  output logic [LINES-1:0] dirty_o,
  output logic [LINES-1:0] wonce_o
);

  st_e           state_q;
  logic [IW-1:0] line_q;
  logic          cache_we_q;
  logic          fill_q;
  logic          mreq_q;
  logic          mwb_q;

  logic          wr_fire;
  logic          ev_fire;
  wr_dec_t       dec;

  logic [IW-1:0] st_idx;
  logic          st_set_d;
  logic          st_clr_d;
  logic          st_set_w;
  logic          st_clr_w;

  assign evict_ready = (state_q == ST_IDLE);
  assign wr_ready    = (state_q == ST_IDLE) && !evict_valid;
  assign ev_fire     = evict_valid && evict_ready;
  assign wr_fire     = wr_valid && wr_ready;

  wp_decide u_decide (
    .pol       (policy),
    .hit       (wr_hit),
    .wonce_bit (wonce_o[wr_line]),
    .dec       (dec)
  );

  always_comb begin
    st_idx   = line_q;
    st_set_d = 1'b0;
    st_clr_d = 1'b0;
    st_set_w = 1'b0;
    st_clr_w = 1'b0;
    if (ev_fire) begin
      st_idx   = evict_line;
      st_clr_d = 1'b1;
      st_clr_w = 1'b1;
    end else if (wr_fire) begin
      st_idx   = wr_line;
      st_set_d = dec.set_dirty;
      st_set_w = dec.set_wonce;
    end else if (state_q == ST_FILL && fill_ack) begin
      st_clr_d = 1'b1;
      st_clr_w = 1'b1;
      st_set_d = 1'b1;
    end
  end

  wp_line_status #(.LINES(LINES)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (st_idx),
    .set_d (st_set_d),
    .clr_d (st_clr_d),
    .set_w (st_set_w),
    .clr_w (st_clr_w),
    .dirty (dirty_o),
    .wonce (wonce_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      line_q     <= '0;
      cache_we_q <= 1'b0;
      fill_q     <= 1'b0;
      mreq_q     <= 1'b0;
      mwb_q      <= 1'b0;
    end else begin
      cache_we_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (ev_fire) begin
            line_q <= evict_line;
            if (dirty_o[evict_line]) begin
              mreq_q  <= 1'b1;
              mwb_q   <= 1'b1;
              state_q <= ST_MEM;
            end
          end else if (wr_fire) begin
            line_q     <= wr_line;
            cache_we_q <= dec.cache_wr;
            if (dec.fill) begin
              fill_q  <= 1'b1;
              state_q <= ST_FILL;
            end else if (dec.mem_wr) begin
              mreq_q  <= 1'b1;
              mwb_q   <= 1'b0;
              state_q <= ST_MEM;
            end
          end
        end
        ST_FILL: begin
          if (fill_ack) begin
            fill_q     <= 1'b0;
            cache_we_q <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        ST_MEM: begin
          if (mem_ack) begin
            mreq_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cache_we   = cache_we_q;
  assign cache_line = line_q;
  assign fill_req   = fill_q;
  assign fill_line  = line_q;
  assign mem_req    = mreq_q;
  assign mem_wb     = mwb_q;
  assign mem_line   = line_q;

endmodule

// File: rtl/wp_ctrl_chk.sv
module wp_ctrl_chk #(
  parameter int LINES = 8,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       policy,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             wr_hit,
  input logic [IW-1:0]    wr_line,
  input logic             evict_valid,
  input logic             evict_ready,
  input logic [IW-1:0]    evict_line,
  input logic             cache_we,
  input logic             fill_req,
  input logic [IW-1:0]    fill_line,
  input logic             fill_ack,
  input logic             mem_req,
  input logic             mem_wb,
  input logic [IW-1:0]    mem_line,
  input logic             mem_ack,
  input logic [LINES-1:0] dirty_o,
  input logic [LINES-1:0] wonce_o
);

  logic acc;
  assign acc = wr_valid && wr_ready;

  p_wb_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wr_hit && (policy == 2'd0) |=> cache_we && !mem_req && dirty_o[$past(wr_line)]);

  p_fill_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && fill_ack |=> cache_we && !fill_req && dirty_o[$past(fill_line)] && !wonce_o[$past(fill_line)]);

  p_wt_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wr_hit && (policy == 2'd1) |=> cache_we && mem_req && !mem_wb && $stable(dirty_o));

  p_wt_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !wr_hit && (policy == 2'd1) |=> !cache_we && !fill_req && mem_req && !mem_wb);

  p_wo_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wr_hit && (policy == 2'd2) && !wonce_o[wr_line] |=> mem_req && !mem_wb && wonce_o[$past(wr_line)]);

  p_wo_later_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wr_hit && (policy == 2'd2) && wonce_o[wr_line] |=> cache_we && !mem_req && dirty_o[$past(wr_line)]);

  p_ev_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid && evict_ready && dirty_o[evict_line] |=> mem_req && mem_wb && (mem_line == $past(evict_line)) && !dirty_o[$past(evict_line)] && !wonce_o[$past(evict_line)]);

  p_ev_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid && evict_ready && !dirty_o[evict_line] |=> !mem_req && !wonce_o[$past(evict_line)]);

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_line) && $stable(mem_wb));

  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || fill_req) |-> !wr_ready && !evict_ready && !(mem_req && fill_req));

  p_evict_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> !wr_ready);

  p_code3_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wr_hit && (policy == 2'd3) |=> !mem_req && dirty_o[$past(wr_line)]);

endmodule

bind wp_ctrl wp_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .policy      (policy),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_hit      (wr_hit),
  .wr_line     (wr_line),
  .evict_valid (evict_valid),
  .evict_ready (evict_ready),
  .evict_line  (evict_line),
  .cache_we    (cache_we),
  .fill_req    (fill_req),
  .fill_line   (fill_line),
  .fill_ack    (fill_ack),
  .mem_req     (mem_req),
  .mem_wb      (mem_wb),
  .mem_line    (mem_line),
  .mem_ack     (mem_ack),
  .dirty_o     (dirty_o),
  .wonce_o     (wonce_o)
);

// File: tb/wp_ctrl_tb_top.sv
`timescale 1ns/1ps
module wp_ctrl_tb_top;

  localparam int LINES = 8;
  localparam int IW = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       policy = 2'd0;
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic             wr_hit = 1'b0;
  logic [IW-1:0]    wr_line = '0;
  logic             evict_valid = 1'b0;
  logic             evict_ready;
  logic [IW-1:0]    evict_line = '0;
  logic             cache_we;
  logic [IW-1:0]    cache_line;
  logic             fill_req;
  logic [IW-1:0]    fill_line;
  logic             fill_ack = 1'b0;
  logic             mem_req;
  logic             mem_wb;
  logic [IW-1:0]    mem_line;
  logic             mem_ack = 1'b0;
  logic [LINES-1:0] dirty_o;
  logic [LINES-1:0] wonce_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  wp_ctrl #(.LINES(LINES)) dut_i (
    .clk (clk), .rst_n (rst_n), .policy (policy),
    .wr_valid (wr_valid), .wr_ready (wr_ready), .wr_hit (wr_hit), .wr_line (wr_line),
    .evict_valid (evict_valid), .evict_ready (evict_ready), .evict_line (evict_line),
    .cache_we (cache_we), .cache_line (cache_line),
    .fill_req (fill_req), .fill_line (fill_line), .fill_ack (fill_ack),
    .mem_req (mem_req), .mem_wb (mem_wb), .mem_line (mem_line), .mem_ack (mem_ack),
    .dirty_o (dirty_o), .wonce_o (wonce_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_wr(input logic [1:0] pol, input logic [IW-1:0] ln, input logic hit);
    policy  = pol;
    wr_line = ln;
    wr_hit  = hit;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic send_ev(input logic [IW-1:0] ln);
    evict_line  = ln;
    evict_valid = 1'b1;
    @(negedge clk);
    evict_valid = 1'b0;
  endtask

  task automatic ack_mem();
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    chk("R10 mem_req drops after ack", 32'(mem_req), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 dirty reset", 32'(dirty_o), 32'd0);
    chk("R1 wonce reset", 32'(wonce_o), 32'd0);
    chk("R1 mem_req reset", 32'(mem_req), 32'd0);
    chk("R1 fill_req reset", 32'(fill_req), 32'd0);
    chk("R1 cache_we reset", 32'(cache_we), 32'd0);
    chk("R1 wr_ready reset", 32'(wr_ready), 32'd1);
    chk("R1 evict_ready reset", 32'(evict_ready), 32'd1);
  endtask

  task automatic t_wb_hit();
    send_wr(2'd0, 3'd3, 1'b1);
    chk("R2 cache_we", 32'(cache_we), 32'd1);
    chk("R2 cache_line", 32'(cache_line), 32'd3);
    chk("R2 no mem_req", 32'(mem_req), 32'd0);
    chk("R2 dirty set", 32'(dirty_o), 32'h08);
    cyc(1);
    chk("R2 cache_we one cycle", 32'(cache_we), 32'd0);
  endtask

  task automatic t_wb_miss();
    send_wr(2'd0, 3'd5, 1'b0);
    chk("R3 fill_req", 32'(fill_req), 32'd1);
    chk("R3 fill_line", 32'(fill_line), 32'd5);
    chk("R3 no cache_we before fill", 32'(cache_we), 32'd0);
    chk("R3 no mem write", 32'(mem_req), 32'd0);
    cyc(2);
    chk("R3 fill_req held", 32'(fill_req), 32'd1);
    chk("R10 wr_ready low during fill", 32'(wr_ready), 32'd0);
    fill_ack = 1'b1;
    @(negedge clk);
    fill_ack = 1'b0;
    chk("R3 fill_req dropped", 32'(fill_req), 32'd0);
    chk("R3 cache_we after fill", 32'(cache_we), 32'd1);
    chk("R3 dirty after fill", 32'(dirty_o[5]), 32'd1);
    chk("R3 wonce clear after fill", 32'(wonce_o[5]), 32'd0);
  endtask

  task automatic t_ev_dirty();
    send_ev(3'd3);
    chk("R8 mem_req", 32'(mem_req), 32'd1);
    chk("R8 mem_wb", 32'(mem_wb), 32'd1);
    chk("R8 mem_line", 32'(mem_line), 32'd3);
    chk("R8 dirty cleared", 32'(dirty_o[3]), 32'd0);
    wr_valid = 1'b1; wr_hit = 1'b1; wr_line = 3'd1; policy = 2'd0;
    cyc(3);
    chk("R10 mem_req held", 32'(mem_req), 32'd1);
    chk("R10 mem_line held", 32'(mem_line), 32'd3);
    chk("R10 mem_wb held", 32'(mem_wb), 32'd1);
    chk("R10 wr_ready low", 32'(wr_ready), 32'd0);
    chk("R10 evict_ready low", 32'(evict_ready), 32'd0);
    chk("R10 stalled write has no effect", 32'(dirty_o[1]), 32'd0);
    wr_valid = 1'b0;
    ack_mem();
  endtask

  task automatic t_ev_clean();
    send_ev(3'd1);
    chk("R9 clean evict no mem_req", 32'(mem_req), 32'd0);
    chk("R9 ready after clean evict", 32'(evict_ready), 32'd1);
  endtask

  task automatic t_wt();
    send_wr(2'd1, 3'd6, 1'b1);
    chk("R4 cache_we", 32'(cache_we), 32'd1);
    chk("R4 mem_req", 32'(mem_req), 32'd1);
    chk("R4 mem_wb word", 32'(mem_wb), 32'd0);
    chk("R4 mem_line", 32'(mem_line), 32'd6);
    chk("R4 dirty unchanged", 32'(dirty_o), 32'h20);
    ack_mem();
    send_wr(2'd1, 3'd4, 1'b0);
    chk("R5 no cache_we", 32'(cache_we), 32'd0);
    chk("R5 no fill", 32'(fill_req), 32'd0);
    chk("R5 mem_req", 32'(mem_req), 32'd1);
    chk("R5 mem_line", 32'(mem_line), 32'd4);
    chk("R5 mem_wb word", 32'(mem_wb), 32'd0);
    ack_mem();
  endtask

  task automatic t_wo();
    send_wr(2'd2, 3'd2, 1'b1);
    chk("R6 cache_we", 32'(cache_we), 32'd1);
    chk("R6 mem_req", 32'(mem_req), 32'd1);
    chk("R6 mem_wb word", 32'(mem_wb), 32'd0);
    chk("R6 wonce set", 32'(wonce_o[2]), 32'd1);
    chk("R6 dirty unchanged", 32'(dirty_o[2]), 32'd0);
    ack_mem();
    send_wr(2'd2, 3'd2, 1'b1);
    chk("R7 cache_we", 32'(cache_we), 32'd1);
    chk("R7 no mem_req", 32'(mem_req), 32'd0);
    chk("R7 dirty set", 32'(dirty_o[2]), 32'd1);
    send_wr(2'd2, 3'd7, 1'b0);
    chk("R3 wo miss fill_req", 32'(fill_req), 32'd1);
    chk("R3 wo miss no mem", 32'(mem_req), 32'd0);
    fill_ack = 1'b1;
    @(negedge clk);
    fill_ack = 1'b0;
    chk("R3 wo miss dirty", 32'(dirty_o[7]), 32'd1);
    chk("R3 wo miss wonce clear", 32'(wonce_o[7]), 32'd0);
    send_ev(3'd2);
    chk("R8 wo line writeback", 32'(mem_req), 32'd1);
    chk("R8 wo line mem_wb", 32'(mem_wb), 32'd1);
    chk("R8 wonce cleared", 32'(wonce_o[2]), 32'd0);
    chk("R8 dirty cleared", 32'(dirty_o[2]), 32'd0);
    ack_mem();
    send_wr(2'd2, 3'd0, 1'b1);
    ack_mem();
    chk("R9 setup wonce", 32'(wonce_o[0]), 32'd1);
    send_ev(3'd0);
    chk("R9 clean wo evict no mem", 32'(mem_req), 32'd0);
    chk("R9 wonce cleared", 32'(wonce_o[0]), 32'd0);
  endtask

  task automatic t_prio();
    policy = 2'd0; wr_line = 3'd1; wr_hit = 1'b1; wr_valid = 1'b1;
    evict_line = 3'd5; evict_valid = 1'b1;
    #1;
    chk("R11 wr_ready low with evict", 32'(wr_ready), 32'd0);
    @(negedge clk);
    wr_valid = 1'b0; evict_valid = 1'b0;
    chk("R11 evict taken", 32'(mem_req), 32'd1);
    chk("R11 evict line", 32'(mem_line), 32'd5);
    chk("R11 write not taken", 32'(cache_we), 32'd0);
    chk("R11 write no dirty", 32'(dirty_o[1]), 32'd0);
    ack_mem();
  endtask

  task automatic t_code3();
    send_wr(2'd3, 3'd0, 1'b1);
    chk("R12 no mem_req", 32'(mem_req), 32'd0);
    chk("R12 dirty set", 32'(dirty_o[0]), 32'd1);
    chk("R12 cache_we", 32'(cache_we), 32'd1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_wb_hit();
    t_wb_miss();
    t_ev_dirty();
    t_ev_clean();
    t_wt();
    t_wo();
    t_prio();
    t_code3();
    cyc(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    total++;
    bad++;
    $display("FAIL watchdog all actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule